// File: doc/BRIEF.md
# MSI Coherence Directory Controller

This block is the central bookkeeping point for coherence in a small multicore system. For a set of line addresses it keeps an MSI state (Invalid, Shared, Modified) and a one-hot vector that marks which cores hold a copy. Per-core cache controllers send it read and write requests over a valid/ready request channel. The block answers each request with a grant on a response channel. When other copies must be removed first, the block sends invalidations only to the cores marked in the vector, over one valid/ready lane per core.

Invalidated cores acknowledge back to the directory on an ack channel, not to the requester. The directory counts these answers against a pending mask. When the mask is empty it sends the requester a single grant. The table is direct-mapped: the low address bits pick an entry, the upper bits are held as a tag, and a tag mismatch counts as Invalid. The directory handles one transaction at a time and keeps the request channel closed until that transaction's grant has been taken.

Message type codes are READ=0, WRITE=1, INV=2 and ACK=3.

Top module: `coh_directory`

## Requirements
- R1: After reset every entry is Invalid with an empty sharer vector, reqReady is 1, and invValid and grantValid are 0. The first request to any line is granted with no invalidation.
- R2: A request whose reqType is not WRITE (code 1) is handled as a read. A read to a line that is Invalid or Shared is granted at once with grantWrite=0. The line becomes Shared and the requester is added to its sharers.
- R3: A read by another core to a Shared line adds that core to the sharer vector and keeps the sharers already present.
- R4: A write raises invValid only for the sharers other than the requester, never for every core. All targeted lanes are raised together, and invAddr carries the line address.
- R5: A write that needs invalidations is granted with grantWrite=1 only after every targeted core has acknowledged. The line then becomes Modified with the writer as its only sharer.
- R6: A write to an Invalid line, or by a core that is the line's only holder, is granted at once with grantWrite=1 and raises no invalidation.
- R7: A read to a line that another core holds Modified invalidates only that owner and waits for its ack. It then grants with grantWrite=0, and the line becomes Shared with the reader as its only sharer.
- R8: A read by the core that holds the line Modified is granted at once with grantWrite=1, and the entry is unchanged.
- R9: An ack is ignored, though consumed, if its type is not ACK (code 3), if its core has no ack outstanding, or if its address differs from invAddr.
- R10: reqReady falls in the cycle after a request is accepted. It stays low until the grant handshake completes and is high again in the following cycle.
- R11: A raised invValid lane stays high until its invReady is seen. grantValid, grantCore, grantAddr and grantWrite hold steady until grantReady.
- R12: A request whose index matches a valid entry with a different tag first invalidates all of that entry's sharers, with invAddr set to the old line address. The request is then served as if the line were Invalid.
- R13: An immediate grant is valid in the cycle after the request is accepted. After the last needed ack is accepted, grantValid rises one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Directory can accept a request |
| reqCore | input | CORE_W | Requesting core ID |
| reqAddr | input | ADDR_W | Line address of the request |
| reqType | input | 2 | Message type, WRITE=1, any other code reads |
| invValid | output | NUM_CORES | Per-core invalidate lane valid |
| invReady | input | NUM_CORES | Per-core invalidate lane ready |
| invAddr | output | ADDR_W | Line address being invalidated |
| ackValid | input | 1 | Acknowledgement present |
| ackReady | output | 1 | Directory is collecting acknowledgements |
| ackCore | input | CORE_W | Core sending the acknowledgement |
| ackAddr | input | ADDR_W | Line address acknowledged |
| ackType | input | 2 | Message type, must be ACK=3 |
| grantValid | output | 1 | Grant present |
| grantReady | input | 1 | Requester takes the grant |
| grantCore | output | CORE_W | Core receiving the grant |
| grantAddr | output | ADDR_W | Line address granted |
| grantWrite | output | 1 | 1 when the line is held Modified by the grantee |

## Verification
The bench uses the default build: four cores, 8-bit addresses and 16 entries, so the tag has four bits. With four cores, sharer masks with one, two and several bits set are all reachable, as are writers that are and are not already in the mask. With 16 entries, addresses 0x05 and 0x15 land on the same entry, so conflict eviction, with its old-address invalidation, can be driven in both directions. Bogus acks of the wrong type, from the wrong core and for the wrong address are sent between real ones. Grant and invalidate stalls are held for several cycles.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    MSG_READ  = 2'd0,
    MSG_WRITE = 2'd1,
    MSG_INV   = 2'd2,
    MSG_ACK   = 2'd3
  } msgTypeT;

  typedef enum logic [1:0] {
    LS_INVALID  = 2'd0,
    LS_SHARED   = 2'd1,
    LS_MODIFIED = 2'd2
  } lineStateT;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_INVAL = 2'd1,
    CS_GRANT = 2'd2
  } ctlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;          // request handshake this cycle
    logic applyImmediate;  // request needs no invalidation: update and grant
    logic applyFinal;      // all acks in: update and grant
    logic ackEnable;       // collecting acknowledgements
  } dirStrobesT;

endpackage

// File: rtl/coh_dir_datapath.sv
module coh_dir_datapath
  import coh_dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 16,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int TAG_W    = ADDR_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dirStrobesT           strobes,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqType,
  input  logic [NUM_CORES-1:0] invReady,
  input  logic                 ackValid,
  input  logic [CORE_W-1:0]    ackCore,
  input  logic [ADDR_W-1:0]    ackAddr,
  input  logic [1:0]           ackType,
  output logic                 needInval,
  output logic                 allDone,
  output logic [NUM_CORES-1:0] invValid,
  output logic [ADDR_W-1:0]    invAddr,
  output logic [CORE_W-1:0]    grantCore,
  output logic [ADDR_W-1:0]    grantAddr,
  output logic                 grantWrite
);

  localparam logic [NUM_CORES-1:0] ONE_BIT = NUM_CORES'(1);

  // line table
  lineStateT            stateTab [NUM_LINES];
  logic [TAG_W-1:0]     tagTab   [NUM_LINES];
  logic [NUM_CORES-1:0] shrTab   [NUM_LINES];

  // captured request
  logic [CORE_W-1:0]    reqCoreQ;
  logic [ADDR_W-1:0]    reqAddrQ;
  logic                 reqWriteQ;
  logic [ADDR_W-1:0]    invAddrQ;
  logic [NUM_CORES-1:0] invPend;
  logic [NUM_CORES-1:0] ackPend;

  // lookup of the incoming request
  logic [IDX_W-1:0]     lkIdx;
  logic [TAG_W-1:0]     lkTag;
  lineStateT            lkState;
  logic [NUM_CORES-1:0] lkShr;
  logic                 lkHit;
  logic                 lkConflict;
  logic                 lkWrite;
  logic [NUM_CORES-1:0] lkReqBit;
  logic [NUM_CORES-1:0] lkTargets;
  logic [ADDR_W-1:0]    lkInvAddr;

  always_comb begin
    lkIdx      = reqAddr[IDX_W-1:0];
    lkTag      = reqAddr[ADDR_W-1:IDX_W];
    lkState    = stateTab[lkIdx];
    lkShr      = shrTab[lkIdx];
    lkHit      = (lkState != LS_INVALID) && (tagTab[lkIdx] == lkTag);
    lkConflict = (lkState != LS_INVALID) && !lkHit;
    lkWrite    = (reqType == MSG_WRITE);
    lkReqBit   = ONE_BIT << reqCore;
    if (lkConflict) begin
      lkTargets = lkShr;
      lkInvAddr = {tagTab[lkIdx], lkIdx};
    end else begin
      lkTargets = (lkHit && (lkWrite || lkState == LS_MODIFIED)) ? (lkShr & ~lkReqBit) : '0;
      lkInvAddr = reqAddr;
    end
  end

  assign needInval = |lkTargets;

  // acknowledgement filtering
  logic ackTake;
  assign ackTake = strobes.ackEnable && ackValid && (ackType == MSG_ACK) &&
                   (ackAddr == invAddrQ) && ackPend[ackCore];

  assign allDone  = (ackPend == '0) && (invPend == '0);
  assign invValid = invPend;
  assign invAddr  = invAddrQ;

  // request capture and pending masks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqCoreQ  <= '0;
      reqAddrQ  <= '0;
      reqWriteQ <= 1'b0;
      invAddrQ  <= '0;
      invPend   <= '0;
      ackPend   <= '0;
    end else if (strobes.accept) begin
      reqCoreQ  <= reqCore;
      reqAddrQ  <= reqAddr;
      reqWriteQ <= lkWrite;
      invAddrQ  <= lkInvAddr;
      invPend   <= lkTargets;
      ackPend   <= lkTargets;
    end else begin
      invPend <= invPend & ~invReady;
      if (ackTake) ackPend <= ackPend & ~(ONE_BIT << ackCore);
    end
  end

  // table update
  logic [IDX_W-1:0] finIdx;
  assign finIdx = reqAddrQ[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        stateTab[i] <= LS_INVALID;
        tagTab[i]   <= '0;
        shrTab[i]   <= '0;
      end
    end else if (strobes.applyImmediate) begin
      if (lkWrite) begin
        stateTab[lkIdx] <= LS_MODIFIED;
        tagTab[lkIdx]   <= lkTag;
        shrTab[lkIdx]   <= lkReqBit;
      end else if (!(lkHit && lkState == LS_MODIFIED)) begin
        stateTab[lkIdx] <= LS_SHARED;
        tagTab[lkIdx]   <= lkTag;
        shrTab[lkIdx]   <= (lkHit ? lkShr : '0) | lkReqBit;
      end
    end else if (strobes.applyFinal) begin
      stateTab[finIdx] <= reqWriteQ ? LS_MODIFIED : LS_SHARED;
      tagTab[finIdx]   <= reqAddrQ[ADDR_W-1:IDX_W];
      shrTab[finIdx]   <= ONE_BIT << reqCoreQ;
    end
  end

  // grant fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantCore  <= '0;
      grantAddr  <= '0;
      grantWrite <= 1'b0;
    end else if (strobes.applyImmediate) begin
      grantCore  <= reqCore;
      grantAddr  <= reqAddr;
      grantWrite <= lkWrite || (lkHit && lkState == LS_MODIFIED);
    end else if (strobes.applyFinal) begin
      grantCore  <= reqCoreQ;
      grantAddr  <= reqAddrQ;
      grantWrite <= reqWriteQ;
    end
  end

endmodule

// File: rtl/coh_dir_control.sv
module coh_dir_control
  import coh_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       grantReady,
  input  logic       needInval,
  input  logic       allDone,
  output logic       reqReady,
  output logic       ackReady,
  output logic       grantValid,
  output dirStrobesT strobes
);

  ctlStateT curState;
  ctlStateT nextState;

  assign reqReady   = (curState == CS_IDLE);
  assign ackReady   = (curState == CS_INVAL);
  assign grantValid = (curState == CS_GRANT);

  always_comb begin
    strobes                = '0;
    strobes.accept         = reqReady && reqValid;
    strobes.applyImmediate = strobes.accept && !needInval;
    strobes.applyFinal     = (curState == CS_INVAL) && allDone;
    strobes.ackEnable      = (curState == CS_INVAL);
  end

  always_comb begin
    nextState = curState;
    unique case (curState)
      CS_IDLE:  if (strobes.accept) nextState = needInval ? CS_INVAL : CS_GRANT;
      CS_INVAL: if (allDone) nextState = CS_GRANT;
      CS_GRANT: if (grantReady) nextState = CS_IDLE;
      default:  nextState = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= CS_IDLE;
    else       curState <= nextState;
  end

endmodule

// File: rtl/coh_directory.sv
module coh_directory
  import coh_dir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 16,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqType,
  output logic [NUM_CORES-1:0] invValid,
  input  logic [NUM_CORES-1:0] invReady,
  output logic [ADDR_W-1:0]    invAddr,
  input  logic                 ackValid,
  output logic                 ackReady,
  input  logic [CORE_W-1:0]    ackCore,
  input  logic [ADDR_W-1:0]    ackAddr,
  input  logic [1:0]           ackType,
  output logic                 grantValid,
  input  logic                 grantReady,
  output logic [CORE_W-1:0]    grantCore,
  output logic [ADDR_W-1:0]    grantAddr,
  output logic                 grantWrite
);

  dirStrobesT strobes;
  logic       needInval;
  logic       allDone;

  coh_dir_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .grantReady (grantReady),
    .needInval  (needInval),
    .allDone    (allDone),
    .reqReady   (reqReady),
    .ackReady   (ackReady),
    .grantValid (grantValid),
    .strobes    (strobes)
  );

  coh_dir_datapath #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .NUM_LINES (NUM_LINES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqCore    (reqCore),
    .reqAddr    (reqAddr),
    .reqType    (reqType),
    .invReady   (invReady),
    .ackValid   (ackValid),
    .ackCore    (ackCore),
    .ackAddr    (ackAddr),
    .ackType    (ackType),
    .needInval  (needInval),
    .allDone    (allDone),
    .invValid   (invValid),
    .invAddr    (invAddr),
    .grantCore  (grantCore),
    .grantAddr  (grantAddr),
    .grantWrite (grantWrite)
  );

endmodule

// File: rtl/coh_dir_checker.sv
module coh_dir_checker #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int CORE_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [NUM_CORES-1:0] invValid,
  input logic [NUM_CORES-1:0] invReady,
  input logic                 ackReady,
  input logic                 grantValid,
  input logic                 grantReady,
  input logic [CORE_W-1:0]    grantCore,
  input logic [ADDR_W-1:0]    grantAddr,
  input logic                 grantWrite
);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r10_ready_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantReady) |=> reqReady);

  a_r10_no_request_while_granting: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> !reqReady);

  a_r11_inv_lane_held: assert property (@(posedge clk) disable iff (!rstN)
    ((invValid & ~invReady) != '0) |=>
      ((invValid & $past(invValid & ~invReady)) == $past(invValid & ~invReady)));

  a_r11_grant_held: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantReady) |=>
      (grantValid && $stable(grantCore) && $stable(grantAddr) && $stable(grantWrite)));

  a_r5_grant_after_invals: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ((invValid == '0) && !ackReady));

  a_r4_inv_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (invValid != '0) |-> (!reqReady && ackReady));

endmodule

bind coh_directory coh_dir_checker #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W),
  .CORE_W    (CORE_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .invValid   (invValid),
  .invReady   (invReady),
  .ackReady   (ackReady),
  .grantValid (grantValid),
  .grantReady (grantReady),
  .grantCore  (grantCore),
  .grantAddr  (grantAddr),
  .grantWrite (grantWrite)
);

// File: tb/coh_directory_bench.sv
module coh_directory_bench;

  localparam int NC = 4;
  localparam int AW = 8;
  localparam int CW = 2;

  localparam logic [1:0] T_READ  = 2'd0;
  localparam logic [1:0] T_WRITE = 2'd1;
  localparam logic [1:0] T_INV   = 2'd2;
  localparam logic [1:0] T_ACK   = 2'd3;

  localparam logic [AW-1:0] LA = 8'h05;
  localparam logic [AW-1:0] LB = 8'h15;
  localparam logic [AW-1:0] LC = 8'h0A;
  localparam logic [AW-1:0] LD = 8'h0C;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [CW-1:0] reqCore = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqType = '0;
  logic [NC-1:0] invValid;
  logic [NC-1:0] invReady = '0;
  logic [AW-1:0] invAddr;
  logic          ackValid = 1'b0;
  logic          ackReady;
  logic [CW-1:0] ackCore = '0;
  logic [AW-1:0] ackAddr = '0;
  logic [1:0]    ackType = '0;
  logic          grantValid;
  logic          grantReady = 1'b0;
  logic [CW-1:0] grantCore;
  logic [AW-1:0] grantAddr;
  logic          grantWrite;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  coh_directory u_coh_directory (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqCore(reqCore),
    .reqAddr(reqAddr), .reqType(reqType),
    .invValid(invValid), .invReady(invReady), .invAddr(invAddr),
    .ackValid(ackValid), .ackReady(ackReady), .ackCore(ackCore),
    .ackAddr(ackAddr), .ackType(ackType),
    .grantValid(grantValid), .grantReady(grantReady), .grantCore(grantCore),
    .grantAddr(grantAddr), .grantWrite(grantWrite)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendReq(input int core, input logic [AW-1:0] addr, input logic [1:0] typ);
    @(negedge clk);
    chk("R10", "reqReady before request", int'(reqReady), 1);
    reqValid = 1'b1; reqCore = CW'(core); reqAddr = addr; reqType = typ;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic sendAck(input int core, input logic [AW-1:0] addr, input logic [1:0] typ);
    @(negedge clk);
    ackValid = 1'b1; ackCore = CW'(core); ackAddr = addr; ackType = typ;
    @(posedge clk); #1;
    ackValid = 1'b0;
  endtask

  task automatic takeGrant(input string req, input int core, input logic [AW-1:0] addr, input int expW);
    chk(req, "grantValid", int'(grantValid), 1);
    chk(req, "grantCore", int'(grantCore), core);
    chk(req, "grantAddr", int'(grantAddr), int'(addr));
    chk(req, "grantWrite", int'(grantWrite), expW);
    grantReady = 1'b1;
    @(posedge clk); #1;
    grantReady = 1'b0;
    @(negedge clk);
    chk("R10", "reqReady after grant", int'(reqReady), 1);
    chk("R10", "grantValid after grant", int'(grantValid), 0);
  endtask

  task automatic reqImm(input string req, input int core, input logic [AW-1:0] addr,
                        input logic [1:0] typ, input int expW);
    sendReq(core, addr, typ);
    @(negedge clk);
    chk(req, "no invalidation", int'(invValid), 0);
    chk("R13", "immediate grant latency", int'(grantValid), 1);
    takeGrant(req, core, addr, expW);
  endtask

  task automatic reqInv(input string req, input int core, input logic [AW-1:0] addr,
                        input logic [1:0] typ, input logic [NC-1:0] expMask,
                        input logic [AW-1:0] expInvAddr, input int expW);
    sendReq(core, addr, typ);
    @(negedge clk);
    chk(req, "invValid mask", int'(invValid), int'(expMask));
    chk(req, "invAddr", int'(invAddr), int'(expInvAddr));
    chk("R10", "reqReady while invalidating", int'(reqReady), 0);
    invReady = '1;
    @(posedge clk); #1;
    invReady = '0;
    for (int i = 0; i < NC; i++) begin
      if (expMask[i]) begin
        @(negedge clk);
        chk(req, "no grant before all acks", int'(grantValid), 0);
        sendAck(i, expInvAddr, T_ACK);
      end
    end
    @(negedge clk);
    chk("R13", "grant one cycle after last ack", int'(grantValid), 0);
    @(negedge clk);
    takeGrant(req, core, addr, expW);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reqReady after reset", int'(reqReady), 1);
    chk("R1", "invValid after reset", int'(invValid), 0);
    chk("R1", "grantValid after reset", int'(grantValid), 0);
  endtask

  task automatic testSharedReads();
    reqImm("R1", 0, LA, T_READ, 0);
    reqImm("R3", 1, LA, T_READ, 0);
  endtask

  // core 2 writes line A shared by cores 0 and 1, with stalls and bogus acks
  task automatic testWriteFanout();
    sendReq(2, LA, T_WRITE);
    @(negedge clk);
    chk("R4", "inv lanes to other sharers", int'(invValid), 4'b0011);
    chk("R4", "invAddr", int'(invAddr), int'(LA));
    @(negedge clk);
    chk("R11", "inv lanes held without ready", int'(invValid), 4'b0011);
    invReady = 4'b0001;
    @(posedge clk); #1;
    invReady = '0;
    @(negedge clk);
    chk("R11", "only readied lane drops", int'(invValid), 4'b0010);
    invReady = 4'b0010;
    @(posedge clk); #1;
    invReady = '0;
    @(negedge clk);
    chk("R4", "all lanes sent", int'(invValid), 0);
    sendAck(0, LA, T_ACK);
    sendAck(1, LA, T_INV);
    sendAck(1, LB, T_ACK);
    sendAck(3, LA, T_ACK);
    @(negedge clk);
    chk("R9", "bogus acks ignored", int'(grantValid), 0);
    @(negedge clk);
    chk("R9", "bogus acks ignored later", int'(grantValid), 0);
    chk("R9", "still collecting acks", int'(ackReady), 1);
    sendAck(1, LA, T_ACK);
    @(negedge clk);
    chk("R13", "grant one cycle after last ack", int'(grantValid), 0);
    @(negedge clk);
    chk("R5", "grant after all acks", int'(grantValid), 1);
    @(negedge clk);
    chk("R11", "grant held", int'(grantValid), 1);
    chk("R11", "grantCore held", int'(grantCore), 2);
    takeGrant("R5", 2, LA, 1);
  endtask

  task automatic testOwnerAccess();
    reqImm("R6", 2, LA, T_WRITE, 1);
    reqImm("R8", 2, LA, T_READ, 1);
  endtask

  task automatic testReadOfModified();
    reqInv("R7", 3, LA, T_READ, 4'b0100, LA, 0);
    reqImm("R7", 3, LA, T_WRITE, 1);
  endtask

  task automatic testConflict();
    reqInv("R12", 1, LB, T_READ, 4'b1000, LA, 0);
    reqInv("R12", 0, LB, T_WRITE, 4'b0010, LB, 1);
    reqInv("R12", 2, LA, T_READ, 4'b0001, LB, 0);
  endtask

  task automatic testFreshLines();
    reqImm("R6", 1, LC, T_WRITE, 1);
    reqImm("R2", 0, LD, T_INV, 0);
    reqImm("R2", 3, LD, T_READ, 0);
    reqInv("R3", 1, LD, T_WRITE, 4'b1001, LD, 1);
  endtask

  initial begin
    testReset();
    testSharedReads();
    testWriteFanout();
    testOwnerAccess();
    testReadOfModified();
    testConflict();
    testFreshLines();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule